// File: doc/BRIEF.md
# Elitist Genetic Search Engine for a Pixel-Array Configuration

This block searches for a good 250-bit configuration word for an external pixel-processing array. On `start` it seeds a population of sixteen candidate words from a 12-bit pseudo-random shift register. It then presents each candidate in turn on `cfg_o`, while the external array filters a test image and streams back pairs of filtered and reference pixels. Each candidate's score is the sum of absolute pixel differences, and a lower score is better.

The engine keeps the single best candidate as the elite. It builds fifteen offspring from the elite by random bit flips, scores only the offspring, and repeats for the requested number of generations. It then places the elite on `chrom_o` and pulses `done`. The score stream uses a valid/ready handshake. The engine raises `pix_ready` only while a candidate is under test. The external side may stall at any time by dropping `pix_valid`, and marks the final pixel of the image with `pix_last`.

Top module: `ga_evolve_ctrl`

## Requirements
- R1: The random source is a 12-bit register that resets to 12'h001 and steps as next = {q[10:0], ~(q[11]^q[5]^q[3]^q[0])}. It never holds the all-ones value.
- R2: After `start`, the engine fills sixteen candidates, one 10-bit group per cycle. Bits [10g+9:10g] of candidate k take the low 10 bits of the random register as held before step number 25k+g, counting from the reset seed. The fill takes 400 cycles, so `pix_ready` first rises 400 clock edges after the edge that samples `start`.
- R3: `pix_ready` is high only while a candidate is being scored. A pixel pair is consumed on a cycle with `pix_valid` and `pix_ready` both high, and `pix_valid` low stalls the stream without loss. `cfg_o` holds the candidate under test and stays unchanged until its `pix_last` transfer. The first generation scores slots 0 to 15, and later generations score slots 1 to 15.
- R4: A candidate's score is the sum over its stream of |`pix_ref` − `pix_filt`|. The score is cleared before each candidate, and a lower score is better.
- R5: The first candidate scored becomes the elite. Afterwards a candidate replaces the elite only if its score is strictly lower, so on a tie the earlier candidate is kept.
- R6: The score holds 20 bits, enough for a 64x64 image of 8-bit differences without wrapping.
- R7: Each offspring slot 1..15 is the elite XOR a flip mask, built one 10-bit group per cycle (25 cycles per slot). Bit j of a group flips when bits [j+3:j] of {q,q} are less than the mutation rate latched from `mut_rate`. A rate of 0 copies the elite unchanged, and a rate of 16 or more writes its complement.
- R8: With `num_gen` = N latched at `start`, the engine stops after the initial generation plus N offspring generations. It then drives the elite on `chrom_o` and raises `done` for exactly one cycle.
- R9: `start`, `num_gen` and `mut_rate` are ignored while a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (sampled only when idle) |
| num_gen | input | 8 | Number of offspring generations after the initial one |
| mut_rate | input | 5 | Bit-flip threshold out of 16 |
| cfg_o | output | 250 | Candidate currently presented to the external array |
| pix_valid | input | 1 | Pixel pair valid |
| pix_ready | output | 1 | Engine accepts pixel pairs (candidate under test) |
| pix_filt | input | 8 | Filtered pixel from the external array |
| pix_ref | input | 8 | Reference pixel |
| pix_last | input | 1 | Marks the last pixel of the image |
| chrom_o | output | 250 | Best configuration found |
| done | output | 1 | One-cycle pulse when `chrom_o` holds the final result |

## Verification
The embedded properties check several behaviours on every cycle: the random register never locks up, `cfg_o` holds still through each scored stream, the score never wraps, the elite score never rises after the first candidate, the search settings stay frozen while the engine is busy, the mutation mask obeys its rate limits, and `done` lasts one cycle.

Other behaviours can only be shown by the bench scenarios. These are the exact seeded contents of all sixteen candidates, the fill latency, which candidate wins under strict-less and tie conditions, and that offspring equal the elite or its complement at the extreme rates. A long 64x64 stream is also needed to show that large scores still rank correctly.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_EVAL,
    ST_JUDGE,
    ST_MUT,
    ST_FIN
  } ga_state_e;

  function automatic logic [7:0] abs_diff8(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr #(
  parameter int         LW   = 12,
  parameter logic [11:0] SEED = 12'h001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [LW-1:0] q
);
  logic fb;

  // taps 12, 6, 4, 1 with xnor feedback
  assign fb = ~(q[11] ^ q[5] ^ q[3] ^ q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= SEED[LW-1:0];
    else if (step) q <= {q[LW-2:0], fb};
  end

  p_no_lockup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q != {LW{1'b1}});
endmodule

// File: rtl/ga_mutate.sv
module ga_mutate #(
  parameter int LW   = 12,
  parameter int GW   = 10,
  parameter int RW   = 5
) (
  input  logic [LW-1:0] rnd,
  input  logic [RW-1:0] rate,
  output logic [GW-1:0] mask
);
  localparam int WIN = RW - 1;
  logic [2*LW-1:0] dbl;

  assign dbl = {rnd, rnd};

  for (genvar j = 0; j < GW; j++) begin : g_bit
    logic [WIN-1:0] win;
    assign win     = dbl[j +: WIN];
    assign mask[j] = ({1'b0, win} < rate);
  end

  always_comb begin
    if (rate == '0)
      p_rate_zero_r7: assert (mask == '0);
    if (rate >= RW'(1 << WIN))
      p_rate_full_r7: assert (mask == {GW{1'b1}});
  end
endmodule

// File: rtl/ga_sad_acc.sv
module ga_sad_acc #(
  parameter int PW = 8,
  parameter int FW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  output logic [FW-1:0] acc
);
  logic [PW-1:0] d;

  assign d = ga_pkg::abs_diff8(a, b);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + FW'(d);
  end

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (acc >= $past(acc)));
endmodule

// File: rtl/ga_evolve_ctrl.sv
module ga_evolve_ctrl #(
  parameter int CHROM_W = 250,
  parameter int GRP_W   = 10,
  parameter int POP     = 16,
  parameter int LFSR_W  = 12,
  parameter int FIT_W   = 20,
  parameter int GEN_W   = 8,
  parameter int RATE_W  = 5,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [GEN_W-1:0]   num_gen,
  input  logic [RATE_W-1:0]  mut_rate,
  output logic [CHROM_W-1:0] cfg_o,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [PIX_W-1:0]   pix_filt,
  input  logic [PIX_W-1:0]   pix_ref,
  input  logic               pix_last,
  output logic [CHROM_W-1:0] chrom_o,
  output logic               done
);
  import ga_pkg::*;

  localparam int NGRP  = CHROM_W / GRP_W;
  localparam int GI_W  = $clog2(NGRP);
  localparam int IDX_W = $clog2(POP);

  ga_state_e           state;
  logic [IDX_W-1:0]    idx;
  logic [GI_W-1:0]     grp;
  logic [GEN_W-1:0]    gen, ngen_q;
  logic [RATE_W-1:0]   rate_q;
  logic [CHROM_W-1:0]  best;
  logic [FIT_W-1:0]    best_fit, fit;
  logic [CHROM_W-1:0]  pop_q [POP];
  logic [LFSR_W-1:0]   rnd;
  logic [GRP_W-1:0]    flip;
  logic                fire, first, grp_end, idx_end;

  assign pix_ready = (state == ST_EVAL);
  assign fire      = pix_valid && pix_ready;
  assign cfg_o     = pop_q[idx];
  assign chrom_o   = best;
  assign first     = (gen == '0) && (idx == '0);
  assign grp_end   = (grp == GI_W'(NGRP - 1));
  assign idx_end   = (idx == IDX_W'(POP - 1));

  ga_lfsr #(.LW(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .step(state == ST_INIT || state == ST_MUT),
    .q(rnd)
  );

  ga_mutate #(.LW(LFSR_W), .GW(GRP_W), .RW(RATE_W)) u_mut (
    .rnd(rnd), .rate(rate_q), .mask(flip)
  );

  ga_sad_acc #(.PW(PIX_W), .FW(FIT_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_JUDGE), .en(fire),
    .a(pix_ref), .b(pix_filt), .acc(fit)
  );

  // population storage
  always_ff @(posedge clk) begin
    if (state == ST_INIT)
      pop_q[idx][grp*GRP_W +: GRP_W] <= rnd[GRP_W-1:0];
    if (state == ST_MUT) begin
      pop_q[idx][grp*GRP_W +: GRP_W] <= best[grp*GRP_W +: GRP_W] ^ flip;
      if (idx == IDX_W'(1) && grp == '0)
        pop_q[0] <= best;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      grp      <= '0;
      gen      <= '0;
      ngen_q   <= '0;
      rate_q   <= '0;
      best     <= '0;
      best_fit <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ngen_q <= num_gen;
          rate_q <= mut_rate;
          idx    <= '0;
          grp    <= '0;
          gen    <= '0;
          state  <= ST_INIT;
        end
        ST_INIT, ST_MUT: begin
          if (grp_end) begin
            grp <= '0;
            if (idx_end) begin
              idx   <= (state == ST_INIT) ? IDX_W'(0) : IDX_W'(1);
              state <= ST_EVAL;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            grp <= grp + 1'b1;
          end
        end
        ST_EVAL: if (fire && pix_last) state <= ST_JUDGE;
        ST_JUDGE: begin
          if (first || fit < best_fit) begin
            best     <= pop_q[idx];
            best_fit <= fit;
          end
          if (idx_end) begin
            if (gen == ngen_q) begin
              state <= ST_FIN;
            end else begin
              gen   <= gen + 1'b1;
              idx   <= IDX_W'(1);
              grp   <= '0;
              state <= ST_MUT;
            end
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_EVAL;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !(pix_valid && pix_last)) |=> (pix_ready && $stable(cfg_o)));

  p_best_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_JUDGE && !first) |=> (best_fit <= $past(best_fit)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_settings_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(ngen_q) && $stable(rate_q)));
endmodule

// File: tb/ga_evolve_ctrl_tb.sv
`timescale 1ns/1ps
module ga_evolve_ctrl_tb_top;
  localparam int CW = 250;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [7:0]    num_gen;
  logic [4:0]    mut_rate;
  logic [CW-1:0] cfg_o;
  logic          pix_valid;
  logic          pix_ready;
  logic [7:0]    pix_filt;
  logic [7:0]    pix_ref;
  logic          pix_last;
  logic [CW-1:0] chrom_o;
  logic          done;

  int n_chk  = 0;
  int n_fail = 0;

  logic [CW-1:0] model [16];

  always #4 clk = ~clk;

  ga_evolve_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num_gen(num_gen),
    .mut_rate(mut_rate), .cfg_o(cfg_o), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_filt(pix_filt), .pix_ref(pix_ref),
    .pix_last(pix_last), .chrom_o(chrom_o), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] lstep(input logic [11:0] q);
    return {q[10:0], ~(q[11] ^ q[5] ^ q[3] ^ q[0])};
  endfunction

  // R1/R2 expected seeded population
  task automatic build_model();
    logic [11:0] q = 12'h001;
    for (int k = 0; k < 16; k++)
      for (int g = 0; g < 25; g++) begin
        model[k][g*10 +: 10] = q[9:0];
        q = lstep(q);
      end
  endtask

  function automatic logic [7:0] fpix(input int mode, input logic [CW-1:0] c, input int p);
    case (mode)
      0: return c[p*8 +: 8];
      1: return 8'h5A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rpix(input int mode, input logic [CW-1:0] c, input int p);
    case (mode)
      0: return 8'h80;
      1: return 8'h5A;
      default: return c[7:0];
    endcase
  endfunction

  function automatic int score(input int mode, input logic [CW-1:0] c, input int npix);
    int s = 0;
    for (int p = 0; p < npix; p++) begin
      int a = fpix(mode, c, p);
      int b = rpix(mode, c, p);
      s += (a > b) ? a - b : b - a;
    end
    return s;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; pix_valid = 1'b0;
    pix_filt = '0; pix_ref = '0; pix_last = 1'b0;
    num_gen = '0; mut_rate = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run(input int mode, input int npix, input int ngen, input int rate,
                     input bit gaps, input bit poke, input bit want_lat, input string tag);
    logic [CW-1:0] snap, exp_best, gen_best;
    int  exp_fit, e, pix_cnt, n, lat;
    bit  busy, fin;
    e = 0; pix_cnt = 0; n = 0; lat = -1; busy = 0; fin = 0;
    exp_best = '0; gen_best = '0; exp_fit = 0;
    num_gen = 8'(ngen); mut_rate = 5'(rate); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    num_gen = 8'hFF; mut_rate = 5'd7;   // R9: changes must not matter while busy
    while (n < 120000) begin
      @(posedge clk); #1; n++;
      start = 1'b0;
      if (done) begin fin = 1; break; end
      if (pix_ready) begin
        if (lat < 0) lat = n;
        if (!busy) begin
          busy = 1; snap = cfg_o; pix_cnt = 0;
          if (e < 16)
            chk(snap == model[e], "R1/R2", $sformatf("seeded slot %0d", e), 256'(snap), 256'(model[e]));
          else begin
            if ((e - 16) % 15 == 0) gen_best = exp_best;
            if (rate == 0)
              chk(snap == gen_best, "R7", "rate 0 offspring", 256'(snap), 256'(gen_best));
            else if (rate >= 16)
              chk(snap == ~gen_best, "R7", "full-rate offspring", 256'(snap), 256'(~gen_best));
          end
          begin
            int s = score(mode, snap, npix);
            if (e == 0 || s < exp_fit) begin exp_fit = s; exp_best = snap; end
          end
          if (poke && e == 3) start = 1'b1;
          e++;
        end
        pix_valid = gaps ? ((n % 3) != 1) : 1'b1;
        pix_filt  = fpix(mode, snap, pix_cnt);
        pix_ref   = rpix(mode, snap, pix_cnt);
        pix_last  = (pix_cnt == npix - 1);
        if (pix_valid) begin
          if (pix_cnt == npix - 1) begin
            chk(cfg_o == snap, "R3", "cfg held during stream", 256'(cfg_o), 256'(snap));
            busy = 0;
          end
          pix_cnt++;
        end
      end else begin
        pix_valid = 1'b0; pix_last = 1'b0;
      end
    end
    pix_valid = 1'b0; pix_last = 1'b0;
    chk(fin, "R8", {tag, " done seen"}, 256'(fin), 256'(1));
    chk(e == 16 + 15 * ngen, "R3/R8", {tag, " candidates scored"}, 256'(e), 256'(16 + 15 * ngen));
    chk(chrom_o == exp_best, tag, "final best chromosome", 256'(chrom_o), 256'(exp_best));
    if (want_lat)
      chk(lat == 400, "R2", "fill latency", 256'(lat), 256'(400));
    @(posedge clk); #1;
    chk(!done, "R8", "done single cycle", 256'(done), 256'(0));
    chk(chrom_o == exp_best, "R8", "result held", 256'(chrom_o), 256'(exp_best));
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    build_model();
    do_reset();
    @(posedge clk); #1;
    chk(!done && !pix_ready, "R3/R8", "reset idle outputs", 256'({done, pix_ready}), 256'(0));
    // R4/R5: mixed-sign differences, stalls on the stream, initial population only
    run(0, 4, 0, 0, 1'b1, 1'b0, 1'b1, "R4/R5");
    // R7: rate 0 keeps the elite across two offspring generations
    do_reset();
    run(0, 4, 2, 0, 1'b1, 1'b0, 1'b0, "R7");
    // R7/R9: full rate, start poked while busy
    do_reset();
    run(0, 4, 1, 16, 1'b0, 1'b1, 1'b0, "R9");
    // R5: all scores equal, slot 0 must win
    do_reset();
    run(1, 3, 1, 16, 1'b1, 1'b0, 1'b0, "R5");
    chk(chrom_o == model[0], "R5", "tie keeps first", 256'(chrom_o), 256'(model[0]));
    // R6: 64x64 image, scores up to 4096*255
    do_reset();
    run(2, 4096, 0, 0, 1'b0, 1'b0, 1'b0, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule